// File: doc/BRIEF.md
# Transmit Queue Enqueue Controller

This block holds the host-facing command logic that decides when frames waiting in a transmit buffer are handed to the transmit engine. The host writes a 16-bit command word to pick one of two modes. In manual mode, a single prepared frame is committed, and the command bit stays set until that frame has left. In automatic mode, every prepared frame is offered with no per-frame command. The two modes never run at the same time.

A second, independent part watches the free transmit memory. Once armed by the host, it compares the free-space count with a requested amount. It emits a one-cycle interrupt pulse when enough room exists, then disarms itself.

Two state machines carry the behaviour. The enqueue machine has states `ENQ_IDLE`, `ENQ_MANUAL` and `ENQ_AUTO`. Its transitions are:
- start-manual: idle to manual
- start-auto: idle to auto
- frame-finished: manual to idle
- auto-off: auto to idle
- auto-to-manual: auto to manual

The monitor machine has states `MON_OFF` and `MON_ARMED`. Its transitions are:
- arm: off to armed
- fire: armed to off

Top module: `txq_enqueue_ctrl`

## Requirements
- R1: After reset the command readback is 0x0000, the enqueue request is low and the interrupt is low.
- R2: Readback layout: bit 0 shows the pending manual enqueue, bit 1 the armed monitor, bit 2 the auto mode. Bits 15 to 3 always read 0.
- R3: In idle, a write with bit 0 = 1 and bit 2 = 0 starts a manual enqueue. From the cycle after the write, bit 0 reads 1 and the enqueue request is high. Both stay that way until the frame finishes, so the host can poll.
- R4: A frame-done pulse during a pending manual enqueue clears bit 0 and drops the enqueue request from the next cycle.
- R5: A write with bit 2 = 1 in idle enters auto mode. In auto mode the enqueue request is high exactly while the prepared-frame count is nonzero. Frame-done pulses do not leave auto mode.
- R6: A write with both bit 0 and bit 2 set enters auto mode only, and bit 0 reads 0.
- R7: In auto mode, a write with bit 2 = 0 leaves auto mode. The block goes to manual if bit 0 of that write is 1, and to idle otherwise.
- R8: A write with bit 1 = 1 arms the monitor. When the monitor is armed at a clock edge where free space >= requested space (unsigned), the interrupt is high for the following cycle.
- R9: The monitor bit reads 0 from the same cycle the interrupt appears. The interrupt lasts one cycle and fires only once per arming.
- R10: A frame-done pulse while nothing is queued is ignored. This covers idle, and auto mode with a zero count. The readback and the enqueue request are unchanged.
- R11: While a manual enqueue is pending, writes to bits 0 and 2 are ignored. While the monitor is armed, a further write of bit 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command register write data |
| prepared_cnt | input | 8 | Number of frames prepared in the buffer |
| frame_done | input | 1 | One-cycle pulse from the transmit engine when a frame finishes |
| free_space | input | 13 | Free transmit memory |
| req_space | input | 13 | Amount of memory the host waits for |
| enq_req | output | 1 | Enqueue request to the transmit engine |
| cmd_rdata | output | 16 | Command register readback |
| mem_avail_irq | output | 1 | One-cycle memory-available interrupt pulse |

## Verification
The hardest situations to reach are the collisions. One is a frame-done pulse or a command write that lands while the other state machine is busy. Another is arming the monitor when free space already meets the request, or re-arming it while it is still armed. Directed sequences set up each of these on purpose. Then a long run with a fixed seed writes random command words, including both-bits-set values, and mixes in random frame-done pulses and space values that often sit near equality. Every cycle of that run is compared against a bench reference model.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int REG_W      = 16;
    localparam int BIT_MANUAL = 0;
    localparam int BIT_MON    = 1;
    localparam int BIT_AUTO   = 2;

    typedef enum logic [1:0] {
        ENQ_IDLE   = 2'd0,
        ENQ_MANUAL = 2'd1,
        ENQ_AUTO   = 2'd2
    } enq_state_e;

    typedef enum logic {
        MON_OFF   = 1'b0,
        MON_ARMED = 1'b1
    } mon_state_e;
endpackage

// File: rtl/txq_enq_fsm.sv
module txq_enq_fsm
    import txq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_manual,
    input  logic             wr_auto,
    input  logic [CNT_W-1:0] prepared_cnt,
    input  logic             frame_done,
    output logic             enq_req,
    output logic             manual_busy,
    output logic             auto_on
);
    enq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENQ_IDLE: begin
                if (wr_en && wr_auto)        state_d = ENQ_AUTO;
                else if (wr_en && wr_manual) state_d = ENQ_MANUAL;
            end
            ENQ_MANUAL: begin
                if (frame_done) state_d = ENQ_IDLE;
            end
            ENQ_AUTO: begin
                if (wr_en && !wr_auto) state_d = wr_manual ? ENQ_MANUAL : ENQ_IDLE;
            end
            default: state_d = ENQ_IDLE;
        endcase
    end

    always_comb begin
        enq_req     = 1'b0;
        manual_busy = 1'b0;
        auto_on     = 1'b0;
        unique case (state_q)
            ENQ_IDLE: ;
            ENQ_MANUAL: begin
                enq_req     = 1'b1;
                manual_busy = 1'b1;
            end
            ENQ_AUTO: begin
                auto_on = 1'b1;
                enq_req = |prepared_cnt;
            end
            default: ;
        endcase
    end

    assert_manual_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENQ_MANUAL && frame_done) |=> (state_q == ENQ_IDLE));

    assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENQ_IDLE && frame_done && !wr_en) |=> (state_q == ENQ_IDLE));

    assert_both_bits_auto_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENQ_IDLE && wr_en && wr_auto && wr_manual) |=> (state_q == ENQ_AUTO));

    assert_manual_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENQ_MANUAL && !frame_done) |=> (state_q == ENQ_MANUAL));
endmodule

// File: rtl/txq_space_mon.sv
module txq_space_mon
    import txq_pkg::*;
#(
    parameter int SPACE_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_wr,
    input  logic [SPACE_W-1:0] free_space,
    input  logic [SPACE_W-1:0] req_space,
    output logic               armed,
    output logic               irq
);
    mon_state_e state_q, state_d;
    logic       hit;
    logic       irq_q;

    assign hit = (free_space >= req_space);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_OFF;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= (state_q == MON_ARMED) && hit;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_OFF:   if (arm_wr) state_d = MON_ARMED;
            MON_ARMED: if (hit)    state_d = MON_OFF;
            default:   state_d = MON_OFF;
        endcase
    end

    always_comb begin
        armed = 1'b0;
        unique case (state_q)
            MON_OFF:   armed = 1'b0;
            MON_ARMED: armed = 1'b1;
            default:   armed = 1'b0;
        endcase
        irq = irq_q;
    end

    assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && hit) |=> (irq && !armed));

    assert_irq_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !armed);
endmodule

// File: rtl/txq_enqueue_ctrl.sv
module txq_enqueue_ctrl
    import txq_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int SPACE_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [REG_W-1:0]   cmd_wdata,
    input  logic [CNT_W-1:0]   prepared_cnt,
    input  logic               frame_done,
    input  logic [SPACE_W-1:0] free_space,
    input  logic [SPACE_W-1:0] req_space,
    output logic               enq_req,
    output logic [REG_W-1:0]   cmd_rdata,
    output logic               mem_avail_irq
);
    logic manual_busy;
    logic auto_on;
    logic mon_armed;

    txq_enq_fsm #(.CNT_W(CNT_W)) u_enq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cmd_wr),
        .wr_manual    (cmd_wdata[BIT_MANUAL]),
        .wr_auto      (cmd_wdata[BIT_AUTO]),
        .prepared_cnt (prepared_cnt),
        .frame_done   (frame_done),
        .enq_req      (enq_req),
        .manual_busy  (manual_busy),
        .auto_on      (auto_on)
    );

    txq_space_mon #(.SPACE_W(SPACE_W)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_wr     (cmd_wr && cmd_wdata[BIT_MON]),
        .free_space (free_space),
        .req_space  (req_space),
        .armed      (mon_armed),
        .irq        (mem_avail_irq)
    );

    always_comb begin
        cmd_rdata             = '0;
        cmd_rdata[BIT_MANUAL] = manual_busy;
        cmd_rdata[BIT_MON]    = mon_armed;
        cmd_rdata[BIT_AUTO]   = auto_on;
    end

    assert_modes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_rdata[BIT_MANUAL] && cmd_rdata[BIT_AUTO]));

    assert_req_needs_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enq_req |-> (cmd_rdata[BIT_MANUAL] || cmd_rdata[BIT_AUTO]));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[REG_W-1:3] == '0);
endmodule

// File: tb/txq_enqueue_ctrl_tb.sv
module txq_enqueue_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [7:0]  prepared_cnt = '0;
    logic        frame_done = 1'b0;
    logic [12:0] free_space = '0;
    logic [12:0] req_space = '0;
    logic        enq_req;
    logic [15:0] cmd_rdata;
    logic        mem_avail_irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference model state: 0 idle, 1 manual, 2 auto
    int m_enq = 0;
    bit m_mon = 0;
    bit m_irq = 0;

    always #2.5 clk = ~clk;

    txq_enqueue_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .prepared_cnt(prepared_cnt), .frame_done(frame_done),
        .free_space(free_space), .req_space(req_space),
        .enq_req(enq_req), .cmd_rdata(cmd_rdata), .mem_avail_irq(mem_avail_irq)
    );

    function automatic logic [15:0] exp_rd();
        return {13'd0, m_enq == 2, m_mon, m_enq == 1};
    endfunction

    function automatic logic exp_enq();
        if (m_enq == 1) return 1'b1;
        if (m_enq == 2) return prepared_cnt != 0;
        return 1'b0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit hit;
        hit = free_space >= req_space;
        m_irq = m_mon && hit;
        if (m_mon) m_mon = !hit;
        else       m_mon = cmd_wr && cmd_wdata[1];
        case (m_enq)
            0: if (cmd_wr && cmd_wdata[2]) m_enq = 2;
               else if (cmd_wr && cmd_wdata[0]) m_enq = 1;
            1: if (frame_done) m_enq = 0;
            default: if (cmd_wr && !cmd_wdata[2]) m_enq = cmd_wdata[0] ? 1 : 0;
        endcase
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 readback model", cmd_rdata, exp_rd());
        chk("R5 enq_req model", enq_req, exp_enq());
        chk("R9 irq model", mem_avail_irq, m_irq);
    endtask

    task automatic drive(bit w, logic [15:0] d, logic [7:0] c, bit fd,
                         logic [12:0] fs, logic [12:0] rq);
        cmd_wr = w; cmd_wdata = d; prepared_cnt = c; frame_done = fd;
        free_space = fs; req_space = rq;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7361));
        repeat (3) @(negedge clk);
        chk("R1 reset rd", cmd_rdata, 16'h0);
        chk("R1 reset enq", enq_req, 1'b0);
        chk("R1 reset irq", mem_avail_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: done with nothing queued
        drive(0, 0, 8'd1, 1, 13'd5, 13'd9); tick();
        chk("R10 idle done rd", cmd_rdata, 16'h0);
        chk("R10 idle done enq", enq_req, 1'b0);

        // R3 manual start and poll
        drive(1, 16'h0001, 8'd1, 0, 13'd5, 13'd9); tick();
        chk("R3 manual rd", cmd_rdata, 16'h0001);
        chk("R3 manual enq", enq_req, 1'b1);
        drive(0, 0, 8'd1, 0, 13'd5, 13'd9); tick();
        chk("R3 manual poll", cmd_rdata, 16'h0001);
        // R11 writes ignored while manual pending
        drive(1, 16'h0004, 8'd1, 0, 13'd5, 13'd9); tick();
        chk("R11 auto write ignored", cmd_rdata, 16'h0001);
        // R4 completion
        drive(0, 0, 8'd1, 1, 13'd5, 13'd9); tick();
        chk("R4 manual cleared rd", cmd_rdata, 16'h0000);
        chk("R4 manual cleared enq", enq_req, 1'b0);

        // R6 both bits -> auto, reserved bits written as ones read 0
        drive(1, 16'hFFFD, 8'd0, 0, 13'd5, 13'd9); tick();
        chk("R6 both bits auto only", cmd_rdata, 16'h0004);
        chk("R5 auto zero count", enq_req, 1'b0);
        drive(0, 0, 8'd3, 0, 13'd5, 13'd9); #1;
        chk("R5 auto nonzero count", enq_req, 1'b1);
        drive(0, 0, 8'd3, 1, 13'd5, 13'd9); tick();
        chk("R5 done stays auto", cmd_rdata, 16'h0004);
        drive(0, 0, 8'd0, 1, 13'd5, 13'd9); tick();
        chk("R10 auto empty done rd", cmd_rdata, 16'h0004);
        chk("R10 auto empty done enq", enq_req, 1'b0);
        // R7 leave auto into manual
        drive(1, 16'h0001, 8'd2, 0, 13'd5, 13'd9); tick();
        chk("R7 auto to manual", cmd_rdata, 16'h0001);
        drive(0, 0, 8'd2, 1, 13'd5, 13'd9); tick();
        drive(1, 16'h0004, 8'd2, 0, 13'd5, 13'd9); tick();
        drive(1, 16'h0000, 8'd2, 0, 13'd5, 13'd9); tick();
        chk("R7 auto off", cmd_rdata, 16'h0000);

        // R8/R9 monitor
        drive(1, 16'h0002, 8'd0, 0, 13'd10, 13'd20); tick();
        chk("R8 armed rd", cmd_rdata, 16'h0002);
        chk("R8 no irq below", mem_avail_irq, 1'b0);
        drive(1, 16'h0002, 8'd0, 0, 13'd19, 13'd20); tick();
        chk("R11 rearm no effect", cmd_rdata, 16'h0002);
        chk("R8 no irq at 19", mem_avail_irq, 1'b0);
        drive(0, 0, 8'd0, 0, 13'd20, 13'd20); tick();
        chk("R8 irq at equal", mem_avail_irq, 1'b1);
        chk("R9 bit clears", cmd_rdata, 16'h0000);
        tick();
        chk("R9 single pulse", mem_avail_irq, 1'b0);
        tick();
        chk("R9 once per arming", mem_avail_irq, 1'b0);
        // arm with space already sufficient
        drive(1, 16'h0002, 8'd0, 0, 13'd100, 13'd3); tick();
        chk("R8 armed first", mem_avail_irq, 1'b0);
        drive(0, 0, 8'd0, 0, 13'd100, 13'd3); tick();
        chk("R8 immediate fire", mem_avail_irq, 1'b1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [12:0] rq;
            rq = 13'($urandom_range(0, 40));
            drive(($urandom_range(0, 9) == 0), 16'($urandom),
                  8'($urandom_range(0, 3)), ($urandom_range(0, 4) == 0),
                  13'(int'(rq) + $urandom_range(0, 6) - 3), rq);
            tick();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule